// File: doc/BRIEF.md
# Four-Output PWM Group with Shadowed Duty Updates

This block is one group of a pulse-width modulation generator. One shared counter sets the timing for four outputs. The outputs are arranged as two pairs.

The counter runs in one of two shapes:
- **Edge-aligned:** it rises and then wraps.
- **Center-aligned:** it climbs to the period value and comes back down.

Output modes:
- **Paired:** the second line of each pair is the inverse of the first.
- **Non-paired:** every line follows its own duty value.

Register writes never change the waveform directly. They land in shadow copies. The shadow copies move into the active set on the clock edge that starts a new period. In center-aligned double-update mode the duty values also move on the edge that reaches the peak, so the falling half of the period can use new duties and produce asymmetric pulses.

Two strobes let surrounding logic follow the timing:
- A period-start strobe, high for one cycle.
- A peak strobe, high for one cycle, in center-aligned mode only.

While the enable is low, the group is idle. The counter sits at zero and the active set follows the shadow set on every cycle, so a newly enabled group begins with whatever was last written.

Top module: `pwm_group`

## Requirements
- R1: After reset, all four outputs and both strobes are low. The shadow and active settings after reset are: period clamped to 2, all duties 0, edge-aligned, non-paired, single update.
- R2: While `enable` is low, all outputs and strobes are low and the counter is held at 0. On every clock edge the active settings are copied from the shadow settings.
- R3: Edge-aligned mode (`mode_center`=0). The count runs 0,1,…,P-1 and wraps, where P is the active period. Output i is high while count < duty_i. `period_start` is high in the cycle where the count is 0.
- R4: Center-aligned mode (`mode_center`=1). The count runs 0,1,…,P,P-1,…,1 and repeats, so one period lasts 2P cycles. Output i is high while count + duty_i > P. `period_start` is high at count 0. `period_mid` is high at count P. The two strobes are never high together.
- R5: In both modes, a duty of 0 keeps an output low for the whole period. A duty of at least P keeps it high for the whole period.
- R6: Paired mode (`mode_paired`=1). `pwm_out[1]` is the inverse of `pwm_out[0]`, and `pwm_out[3]` is the inverse of `pwm_out[2]`. Duty slots 1 and 3 have no effect.
- R7: Non-paired mode. `pwm_out[i]` follows duty slot i, where slot i is selected by `duty_sel`=i.
- R8: Writes to period, duty and mode go to shadow registers. They reach the active set only on the edge on which the count returns to 0. Between such edges the waveform keeps its old settings.
- R9: Center-aligned double update (`mode_double`=1). Duties are also copied from shadow to active on the edge on which the count reaches P. Period and mode are not copied there.
- R10: Center-aligned single update (`mode_double`=0). Duties are not copied at the peak, so each pulse is symmetric about the peak.
- R11: A written period below 2 is used as 2.
- R12: A write to a shadow register on the same edge as a copy is not part of that copy. The copy takes the value the shadow held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the group when high |
| wr_period | input | 1 | Write strobe for the period shadow |
| period_in | input | CW | Period value |
| wr_duty | input | 1 | Write strobe for one duty shadow |
| duty_sel | input | 2 | Duty slot selected for writing |
| duty_in | input | CW | Duty value |
| wr_mode | input | 1 | Write strobe for the mode shadow |
| mode_center | input | 1 | 1 = center-aligned, 0 = edge-aligned |
| mode_paired | input | 1 | 1 = complementary pairs |
| mode_double | input | 1 | 1 = extra duty copy at the peak |
| pwm_out | output | 4 | PWM lines |
| period_start | output | 1 | Strobe at count 0 |
| period_mid | output | 1 | Strobe at the center-aligned peak |

## Verification
Directed segments target one behaviour each:
- Edge-aligned and center-aligned runs with mixed duties separate the two comparison rules.
- Duty values of 0, exactly P and above P check the saturation at both ends.
- Paired runs with conflicting odd-slot duties show that those slots are ignored.
- Duty writes spread across a center-aligned period, once with single update and once with double update, show whether the peak copy happens.

Constrained random traffic then mixes these writes with period changes that include 0 and 1, mode switches and enable toggles. This exposes timing errors in when the copies happen and in how a write on the copy edge is handled. Expected values come from a bench model that tracks a phase count rather than a direction flag.

// File: rtl/pwm_grp_pkg.sv
package pwm_grp_pkg;
  localparam int NOUT = 4;
  localparam int SELW = $clog2(NOUT);

  typedef struct packed {
    logic center;
    logic paired;
    logic dbl;
  } pwm_mode_t;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          center,
  input  logic          dbl,
  input  logic [CW-1:0] per,
  output logic [CW-1:0] cnt,
  output logic          load_start,
  output logic          load_mid,
  output logic          strobe_start,
  output logic          strobe_mid
);
  logic dn;
  logic wrap_evt;
  logic peak_evt;

  always_comb begin
    wrap_evt     = center ? (dn && cnt == CW'(1)) : (cnt == per - CW'(1));
    peak_evt     = center && !dn && (cnt == per - CW'(1));
    load_start   = !en || wrap_evt;
    load_mid     = en && peak_evt && dbl;
    strobe_start = en && (cnt == '0);
    strobe_mid   = en && center && dn && (cnt == per);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      dn  <= 1'b0;
    end else if (load_start) begin
      cnt <= '0;
      dn  <= 1'b0;
    end else if (peak_evt) begin
      cnt <= per;
      dn  <= 1'b1;
    end else if (dn) begin
      cnt <= cnt - CW'(1);
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !center) |-> (cnt < per));
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && center) |-> (cnt <= per));
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_mid |-> !strobe_start);
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && load_start) |=> (cnt == '0));
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow
  import pwm_grp_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_period,
  input  logic [CW-1:0]            period_in,
  input  logic                     wr_duty,
  input  logic [SELW-1:0]          duty_sel,
  input  logic [CW-1:0]            duty_in,
  input  logic                     wr_mode,
  input  pwm_mode_t                mode_in,
  input  logic                     load_start,
  input  logic                     load_mid,
  output logic [CW-1:0]            act_per,
  output logic [NOUT-1:0][CW-1:0]  act_duty,
  output pwm_mode_t                act_mode
);
  function automatic logic [CW-1:0] eff_per(input logic [CW-1:0] p);
    return (p < CW'(2)) ? CW'(2) : p;
  endfunction

  logic [CW-1:0] sh_per;
  pwm_mode_t     sh_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_per   <= '0;
      sh_mode  <= '0;
      act_per  <= CW'(2);
      act_mode <= '0;
    end else begin
      if (wr_period) sh_per  <= period_in;
      if (wr_mode)   sh_mode <= mode_in;
      if (load_start) begin
        act_per  <= eff_per(sh_per);
        act_mode <= sh_mode;
      end
    end
  end

  for (genvar i = 0; i < NOUT; i++) begin : g_slot
    logic [CW-1:0] sh_duty;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh_duty     <= '0;
        act_duty[i] <= '0;
      end else begin
        if (wr_duty && duty_sel == SELW'(i)) sh_duty <= duty_in;
        if (load_start || load_mid) act_duty[i] <= sh_duty;
      end
    end
  end

  p_duty_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_start && !load_mid) |=> $stable(act_duty));
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_start |=> ($stable(act_per) && $stable(act_mode)));
  p_per_floor_r11: assert property (@(posedge clk) disable iff (!rst_n)
    act_per >= CW'(2));
endmodule

// File: rtl/pwm_outmux.sv
module pwm_outmux
  import pwm_grp_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [CW-1:0]           cnt,
  input  logic [CW-1:0]           per,
  input  logic [NOUT-1:0][CW-1:0] duty,
  input  pwm_mode_t               mode,
  output logic [NOUT-1:0]         pwm_out
);
  function automatic logic level(input logic [CW-1:0] c, input logic [CW-1:0] d,
                                 input logic [CW-1:0] p, input logic ctr);
    if (d == '0)  return 1'b0;
    if (d >= p)   return 1'b1;
    if (ctr)      return ({1'b0, c} + {1'b0, d}) > {1'b0, p};
    return c < d;
  endfunction

  for (genvar g = 0; g < NOUT / 2; g++) begin : g_pair
    logic lead, trail;
    always_comb begin
      lead  = level(cnt, duty[2*g],   per, mode.center);
      trail = level(cnt, duty[2*g+1], per, mode.center);
      pwm_out[2*g]   = en && lead;
      pwm_out[2*g+1] = en && (mode.paired ? !lead : trail);
    end

    p_comp_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && mode.paired) |-> (pwm_out[2*g+1] == !pwm_out[2*g]));
  end

  p_off_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (pwm_out == '0));
endmodule

// File: rtl/pwm_group.sv
module pwm_group
  import pwm_grp_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            wr_period,
  input  logic [CW-1:0]   period_in,
  input  logic            wr_duty,
  input  logic [SELW-1:0] duty_sel,
  input  logic [CW-1:0]   duty_in,
  input  logic            wr_mode,
  input  logic            mode_center,
  input  logic            mode_paired,
  input  logic            mode_double,
  output logic [NOUT-1:0] pwm_out,
  output logic            period_start,
  output logic            period_mid
);
  logic [CW-1:0]           cnt;
  logic [CW-1:0]           act_per;
  logic [NOUT-1:0][CW-1:0] act_duty;
  pwm_mode_t               act_mode;
  pwm_mode_t               mode_wr;
  logic                    load_start, load_mid;

  assign mode_wr = '{center: mode_center, paired: mode_paired, dbl: mode_double};

  pwm_timebase #(.CW(CW)) u_tb (
    .clk, .rst_n, .en(enable), .center(act_mode.center), .dbl(act_mode.dbl),
    .per(act_per), .cnt, .load_start, .load_mid,
    .strobe_start(period_start), .strobe_mid(period_mid)
  );

  pwm_shadow #(.CW(CW)) u_sh (
    .clk, .rst_n, .wr_period, .period_in, .wr_duty, .duty_sel, .duty_in,
    .wr_mode, .mode_in(mode_wr), .load_start, .load_mid,
    .act_per, .act_duty, .act_mode
  );

  pwm_outmux #(.CW(CW)) u_om (
    .clk, .rst_n, .en(enable), .cnt, .per(act_per), .duty(act_duty),
    .mode(act_mode), .pwm_out
  );

  p_mid_center_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_mid |-> (act_mode.center && act_mode.dbl));
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!period_start && !period_mid));
endmodule

// File: tb/tb_pwm_group.sv
`timescale 1ns/1ps
module tb_pwm_group;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, wr_period = 1'b0, wr_duty = 1'b0, wr_mode = 1'b0;
  logic [CW-1:0] period_in = '0, duty_in = '0;
  logic [1:0] duty_sel = '0;
  logic mode_center = 1'b0, mode_paired = 1'b0, mode_double = 1'b0;
  logic [3:0] pwm_out;
  logic period_start, period_mid;

  int vecs = 0, fails = 0;
  string cur_tag = "R1";

  always #4 clk = ~clk;

  pwm_group #(.CW(CW)) dut (
    .clk, .rst_n, .enable, .wr_period, .period_in, .wr_duty, .duty_sel,
    .duty_in, .wr_mode, .mode_center, .mode_paired, .mode_double,
    .pwm_out, .period_start, .period_mid
  );

  // Reference model: a phase index 0..len-1 instead of an up/down counter
  int ph, ap, ad[4], sp, sd[4];
  bit acen, apair, adbl, sc, spr, sdb;

  function automatic int effp(int p);
    return (p < 2) ? 2 : p;
  endfunction
  function automatic int cnt_of(int phase, int p, bit cen);
    return (cen && phase > p) ? 2 * p - phase : phase;
  endfunction
  function automatic bit lvl_m(int c, int d, int p, bit cen);
    if (d == 0) return 1'b0;
    if (d >= p) return 1'b1;
    return cen ? (c > p - d) : (c < d);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; ap = 2; acen = 0; apair = 0; adbl = 0; sp = 0; sc = 0; spr = 0; sdb = 0;
      for (int i = 0; i < 4; i++) begin ad[i] = 0; sd[i] = 0; end
    end else begin
      int len;
      bit ld_s, ld_m;
      len  = acen ? 2 * ap : ap;
      ld_s = !enable || (ph == len - 1);
      ld_m = enable && acen && adbl && (ph == ap - 1);
      ph   = ld_s ? 0 : ph + 1;
      if (ld_s) begin ap = effp(sp); acen = sc; apair = spr; adbl = sdb; end
      if (ld_s || ld_m) for (int i = 0; i < 4; i++) ad[i] = sd[i];
      if (wr_period) sp = int'(period_in);
      if (wr_mode) begin sc = mode_center; spr = mode_paired; sdb = mode_double; end
      if (wr_duty) sd[duty_sel] = int'(duty_in);
    end
  end

  always @(negedge clk) begin
    int c;
    bit [3:0] raw, e;
    bit es, em;
    string t;
    c = cnt_of(ph, ap, acen);
    for (int i = 0; i < 4; i++) raw[i] = lvl_m(c, ad[i], ap, acen);
    e[0] = enable && raw[0];
    e[1] = enable && (apair ? !raw[0] : raw[1]);
    e[2] = enable && raw[2];
    e[3] = enable && (apair ? !raw[2] : raw[3]);
    es = enable && (c == 0);
    em = enable && acen && (ph == ap);
    vecs++;
    if (cur_tag != "") t = cur_tag;
    else if (!enable) t = "R2";
    else if (apair) t = "R6";
    else if (acen) t = adbl ? "R9" : "R10";
    else t = "R3";
    if (pwm_out !== e) begin
      fails++;
      $display("FAIL %s: pwm_out=%b expected %b (t=%0t)", t, pwm_out, e, $time);
    end
    if (period_start !== es || period_mid !== em) begin
      fails++;
      $display("FAIL %s: strobes start/mid=%b%b expected %b%b (t=%0t)",
               t, period_start, period_mid, es, em, $time);
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask
  task automatic set_period(int v);
    wr_period = 1; period_in = CW'(v); step(); wr_period = 0;
  endtask
  task automatic set_duty(int s, int v);
    wr_duty = 1; duty_sel = 2'(s); duty_in = CW'(v); step(); wr_duty = 0;
  endtask
  task automatic set_mode(bit c, bit p, bit d);
    wr_mode = 1; mode_center = c; mode_paired = p; mode_double = d; step(); wr_mode = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D));
    step(4);
    rst_n = 1; step(2);                       // R1 reset state
    cur_tag = "R2";
    set_period(10); set_duty(0, 3); set_duty(1, 7); set_duty(2, 5); set_duty(3, 9);
    step(5);
    cur_tag = "R3"; enable = 1; step(40);
    cur_tag = "R7";
    set_duty(0, 2); set_duty(1, 4); set_duty(2, 6); set_duty(3, 8); step(40);
    cur_tag = "R4"; set_mode(1, 0, 0); step(60);
    cur_tag = "R5";
    set_duty(0, 0); set_duty(1, 10); set_duty(2, 15); set_duty(3, 9); step(50);
    set_mode(0, 0, 0); step(40);
    cur_tag = "R6"; set_duty(1, 0); set_duty(3, 12);
    set_mode(1, 1, 0); step(40); set_mode(0, 1, 0); step(30);
    cur_tag = "R8"; set_mode(0, 0, 0); step(3); set_duty(0, 6); step(30);
    set_period(6); step(5); set_mode(1, 0, 0); step(40);
    cur_tag = "R9"; set_period(8); set_mode(1, 0, 1);
    for (int k = 0; k < 12; k++) begin set_duty(k % 4, $urandom % 10); step(4); end
    cur_tag = "R10"; set_mode(1, 0, 0);
    for (int k = 0; k < 12; k++) begin set_duty(k % 4, $urandom % 10); step(4); end
    cur_tag = "R11"; set_period(0); step(20); set_period(1); step(20);
    set_mode(0, 1, 0); step(20);
    cur_tag = "R12";
    for (int k = 0; k < 40; k++) begin set_duty(k % 4, k % 5); end
    cur_tag = "";
    for (int k = 0; k < 15000; k++) begin
      int r;
      r = $urandom % 400;
      if (r < 60) set_duty($urandom % 4, $urandom % 24);
      else if (r < 70) set_period($urandom % 20);
      else if (r < 77) set_mode($urandom % 2, $urandom % 2, $urandom % 2);
      else if (r < 79) begin enable = !enable; step(); end
      else step();
      if (!enable && ($urandom % 8 == 0)) enable = 1;
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule